// File: doc/BRIEF.md
# Address-Range Cache Scrubber

This block is built into a small set-associative cache. It holds the cache's tag array and removes stale lines when an outside coherency agent reports that a stretch of memory has been overwritten. The scrubber does not flush the whole cache. It takes a range request, which is a line-aligned start address and a length counted in lines. It then checks one set per cycle, comparing every way of that set in parallel, and clears the valid bit of each line whose address falls inside the range. Lines outside the range are left alone, so data that other work depends on stays cached.

Normal cache traffic always gets the tags first. This traffic is lookups, plus installs of new lines by the cache controller. In any cycle where either one touches the tags, the walk holds its place. When the last set has been checked, the block pulses a done signal for one cycle. Every instance in a large design has the same request interface: a valid/ready handshake carrying start and length, and a done pulse.

A line address is split into two parts. The low `SET_W` bits (`SET_W = log2(SETS)`) are the set index. The remaining upper bits are the tag.

Top module: `range_scrubber`

## Requirements
- R1: After reset, every line is invalid, `req_ready` is 1 and `done_o` is 0.
- R2: A request is accepted only while `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance until the walk ends. A `req_valid` raised during a walk has no effect on any line.
- R3: A valid line whose line address `a` satisfies `start <= a < start + len` is invalid after `done_o` rises.
- R4: A valid line outside that interval stays valid. This includes the line at `start - 1`, the line at `start + len`, and the other ways of a set that holds a matching line.
- R5: With no tag traffic, `done_o` is 1 in exactly the cycle after the `SETS`-th rising edge following the accepting edge. It is 0 in the cycle after that, and `req_ready` is 1 while `done_o` is 1.
- R6: Each clock edge during a walk at which `lk_valid` or `fill_valid` is 1 delays `done_o` by one cycle, and no line is cleared at that edge.
- R7: A request with `len = 0` clears nothing and still completes with a done pulse after `SETS` edges.
- R8: `lk_hit` is 1 in the same cycle exactly when the set of `lk_addr` holds a valid way whose tag equals the upper bits of `lk_addr`. `lk_way` then gives that way's index. A line cleared at an earlier edge reads as a miss.
- R9: `fill_valid` writes the tag of `fill_addr` into way `fill_way` of its set and marks that line valid at the next edge.
- R10: The end of a range is computed one bit wider than the address, so it does not wrap. A range that runs past the top address leaves low addresses valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Range request present |
| req_ready | output | 1 | Scrubber idle; request taken on valid and ready |
| req_start | input | ADDR_W | First line address of the range |
| req_len | input | ADDR_W | Number of lines in the range |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| lk_valid | input | 1 | Lookup uses the tags this cycle |
| lk_addr | input | ADDR_W | Line address looked up |
| lk_hit | output | 1 | Lookup found a valid matching line |
| lk_way | output | WAY_W | Way of the hit |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | ADDR_W | Line address installed |
| fill_way | input | WAY_W | Way written by the install |

## Verification
The assertions assume three things about the cache controller. `lk_valid` and `fill_valid` are known after reset. A request is held only with sensible values: a length may be zero, but the sum of start and length never goes beyond one bit past the address width. Tag traffic never stalls a walk forever. The bench keeps to these rules. It drives inputs only at falling edges, and it ends every stall burst after a few cycles. It never raises tag traffic and a new request in the same cycle unless it is deliberately testing that a request made during a walk is ignored.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/rs_tag_store.sv
module rs_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            lk_set,
    output logic [WAYS-1:0]             lk_vld,
    output logic [WAYS-1:0][TAG_W-1:0]  lk_tag,
    input  logic [SET_W-1:0]            sc_set,
    output logic [WAYS-1:0]             sc_vld,
    output logic [WAYS-1:0][TAG_W-1:0]  sc_tag,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        clr_en,
    input  logic [SET_W-1:0]            clr_set,
    input  logic [WAYS-1:0]             clr_mask
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
    } store_t;

    store_t st_d, st_q;

    assign lk_vld = st_q.vld[lk_set];
    assign lk_tag = st_q.tag[lk_set];
    assign sc_vld = st_q.vld[sc_set];
    assign sc_tag = st_q.tag[sc_set];

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.vld[clr_set] = st_q.vld[clr_set] & ~clr_mask;
        end
        if (wr_en) begin
            st_d.vld[wr_set][wr_way] = 1'b1;
            st_d.tag[wr_set][wr_way] = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_range_match.sv
module rs_range_match #(
    parameter int ADDR_W = 16,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W
) (
    input  logic [SET_W-1:0]            set_idx,
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag,
    input  logic [ADDR_W-1:0]           rng_start,
    input  logic [ADDR_W-1:0]           rng_len,
    output logic [WAYS-1:0]             hit_mask
);
    logic [ADDR_W:0] lo_ext;
    logic [ADDR_W:0] hi_ext;

    assign lo_ext = {1'b0, rng_start};
    assign hi_ext = {1'b0, rng_start} + {1'b0, rng_len};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [ADDR_W:0] line_ext;
        assign line_ext    = {1'b0, tag[w], set_idx};
        assign hit_mask[w] = vld[w] && (line_ext >= lo_ext) && (line_ext < hi_ext);
    end
endmodule

// File: rtl/rs_walker.sv
module rs_walker
    import rs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 16,
    localparam int SET_W = $clog2(SETS),
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_len,
    input  logic              stall,
    output logic              req_ready,
    output logic              busy,
    output logic              step,
    output logic [SET_W-1:0]  set_idx,
    output logic [ADDR_W-1:0] rng_start,
    output logic [ADDR_W-1:0] rng_len,
    output logic              done
);
    typedef struct packed {
        walk_state_e       state;
        logic [SET_W-1:0]  set;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] len;
        logic              done;
    } walk_t;

    walk_t w_d, w_q;

    assign req_ready = (w_q.state == WALK_IDLE);
    assign busy      = (w_q.state == WALK_BUSY);
    assign step      = busy && !stall;
    assign set_idx   = w_q.set;
    assign rng_start = w_q.start;
    assign rng_len   = w_q.len;
    assign done      = w_q.done;

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        unique case (w_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    w_d.state = WALK_BUSY;
                    w_d.set   = '0;
                    w_d.start = req_start;
                    w_d.len   = req_len;
                end
            end
            WALK_BUSY: begin
                if (!stall) begin
                    if (w_q.set == LAST_SET) begin
                        w_d.state = WALK_IDLE;
                        w_d.done  = 1'b1;
                    end else begin
                        w_d.set = w_q.set + 1'b1;
                    end
                end
            end
            default: w_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{state: WALK_IDLE, set: '0, start: '0, len: '0, done: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end
endmodule

// File: rtl/range_scrubber.sv
module range_scrubber #(
    parameter int ADDR_W = 16,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_len,
    output logic              done_o,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WAY_W-1:0]  fill_way
);
    logic                        tag_busy;
    logic                        walk_busy;
    logic                        walk_step;
    logic [SET_W-1:0]            walk_set;
    logic [ADDR_W-1:0]           rng_start;
    logic [ADDR_W-1:0]           rng_len;
    logic [WAYS-1:0]             lk_vld;
    logic [WAYS-1:0][TAG_W-1:0]  lk_tag;
    logic [WAYS-1:0]             sc_vld;
    logic [WAYS-1:0][TAG_W-1:0]  sc_tag;
    logic [WAYS-1:0]             sc_mask;
    logic [WAYS-1:0]             lk_match;

    // Normal tag traffic owns the tag array; the walk yields to it.
    assign tag_busy = lk_valid | fill_valid;

    rs_walker #(
        .ADDR_W (ADDR_W),
        .SETS   (SETS)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_start (req_start),
        .req_len   (req_len),
        .stall     (tag_busy),
        .req_ready (req_ready),
        .busy      (walk_busy),
        .step      (walk_step),
        .set_idx   (walk_set),
        .rng_start (rng_start),
        .rng_len   (rng_len),
        .done      (done_o)
    );

    rs_tag_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (lk_addr[SET_W-1:0]),
        .lk_vld   (lk_vld),
        .lk_tag   (lk_tag),
        .sc_set   (walk_set),
        .sc_vld   (sc_vld),
        .sc_tag   (sc_tag),
        .wr_en    (fill_valid),
        .wr_set   (fill_addr[SET_W-1:0]),
        .wr_way   (fill_way),
        .wr_tag   (fill_addr[ADDR_W-1:SET_W]),
        .clr_en   (walk_step),
        .clr_set  (walk_set),
        .clr_mask (sc_mask)
    );

    rs_range_match #(
        .ADDR_W (ADDR_W),
        .SETS   (SETS),
        .WAYS   (WAYS)
    ) u_match (
        .set_idx   (walk_set),
        .vld       (sc_vld),
        .tag       (sc_tag),
        .rng_start (rng_start),
        .rng_len   (rng_len),
        .hit_mask  (sc_mask)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_lk
        assign lk_match[w] = lk_vld[w] && (lk_tag[w] == lk_addr[ADDR_W-1:SET_W]);
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/rs_scrub_chk.sv
module rs_scrub_chk #(
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done_o,
    input logic             lk_valid,
    input logic             fill_valid,
    input logic             walk_busy,
    input logic             walk_step,
    input logic [SET_W-1:0] walk_set
);
    // R2: an accepted request makes the block busy on the next cycle
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: no set is cleared while idle
    p_idle_no_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !walk_step);

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: done coincides with an idle scrubber
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready);

    // R6: tag traffic blocks clearing in that cycle
    p_stall_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid || fill_valid) |-> !walk_step);

    // R6: a stalled walk keeps its set and does not finish
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && (lk_valid || fill_valid)) |=> ($stable(walk_set) && !done_o));
endmodule

bind range_scrubber rs_scrub_chk #(.SET_W(SET_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done_o     (done_o),
    .lk_valid   (lk_valid),
    .fill_valid (fill_valid),
    .walk_busy  (walk_busy),
    .walk_step  (walk_step),
    .walk_set   (walk_set)
);

// File: tb/range_scrubber_tb.sv
module range_scrubber_tb;
    localparam int ADDR_W = 16;
    localparam int SETS   = 16;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int NV     = 12;

    // Table: range start, range length, probed line, expected hit, requirement code
    localparam logic [15:0] V_START [NV] = '{16'h0100, 16'h0100, 16'h0100, 16'h0100,
        16'h0100, 16'hFFF0, 16'hFFF0, 16'h1234, 16'h1234, 16'h0003, 16'h0003, 16'h0003};
    localparam logic [15:0] V_LEN   [NV] = '{16'h0020, 16'h0020, 16'h0020, 16'h0020,
        16'h0000, 16'h0020, 16'h0020, 16'h0001, 16'h0001, 16'h1000, 16'h1000, 16'h1000};
    localparam logic [15:0] V_PROBE [NV] = '{16'h0100, 16'h011F, 16'h0120, 16'h00FF,
        16'h0100, 16'h0005, 16'hFFF5, 16'h1234, 16'h1244, 16'h0FF2, 16'h0002, 16'h1003};
    localparam logic        V_HIT   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int          V_REQ   [NV] = '{3, 3, 4, 4, 7, 10, 10, 3, 4, 3, 4, 4};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_start = '0;
    logic [ADDR_W-1:0] req_len = '0;
    logic              done_o;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [WAY_W-1:0]  fill_way = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    range_scrubber #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_len(req_len), .done_o(done_o),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way)
    );

    function automatic string req_name(int code);
        case (code)
            3:  return "R3";
            4:  return "R4";
            7:  return "R7";
            10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic install(logic [ADDR_W-1:0] a, int way);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_way   = WAY_W'(way);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic probe(logic [ADDR_W-1:0] a, output logic hit, output logic [WAY_W-1:0] way);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        #1;
        hit = lk_hit;
        way = lk_way;
        lk_valid = 1'b0;
    endtask

    // Runs one range request; returns edges from acceptance to the done pulse.
    task automatic scrub(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] n,
                         int stall_n, bit inject, output int cnt);
        @(negedge clk);
        req_valid = 1'b1;
        req_start = s;
        req_len   = n;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (cnt < 1000) begin
            lk_valid  = (cnt >= 2) && (cnt < 2 + stall_n);
            lk_addr   = '0;
            req_valid = inject && (cnt == 3);
            if (inject && cnt == 3) begin
                req_start = 16'h0300;
                req_len   = 16'h0010;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) check("R2", int'(req_ready), 0, "ready during walk");
            if (done_o) break;
        end
        lk_valid  = 1'b0;
        req_valid = 1'b0;
        check("R5", int'(req_ready), 1, "ready with done");
        @(negedge clk);
        check("R5", int'(done_o), 0, "done is one cycle");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic             h;
        logic [WAY_W-1:0] w;
        int               n;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(req_ready), 1, "ready after reset");
        check("R1", int'(done_o), 0, "done after reset");
        probe(16'h0100, h, w);
        check("R1", int'(h), 0, "line valid during reset");
        rst_n = 1'b1;
        probe(16'h0000, h, w);
        check("R1", int'(h), 0, "line valid after reset");

        // R9 / R8: install then look up
        install(16'h0A57, 2);
        probe(16'h0A57, h, w);
        check("R9", int'(h), 1, "installed line hit");
        check("R8", int'(w), 2, "hit way");
        probe(16'h0B57, h, w);
        check("R8", int'(h), 0, "other tag same set");

        // Table walk over ranges
        for (int i = 0; i < NV; i++) begin
            install(V_PROBE[i], i % WAYS);
            scrub(V_START[i], V_LEN[i], 0, 1'b0, n);
            check("R5", n, SETS, "walk length");
            probe(V_PROBE[i], h, w);
            check(req_name(V_REQ[i]), int'(h), int'(V_HIT[i]), "probe after range");
        end

        // R4 / R8: only one way of a full set is cleared
        install(16'h0150, 0);
        install(16'h0250, 1);
        install(16'h0350, 2);
        install(16'h0450, 3);
        scrub(16'h0250, 16'h0001, 0, 1'b0, n);
        probe(16'h0250, h, w);
        check("R8", int'(h), 0, "cleared way reads miss");
        probe(16'h0150, h, w);
        check("R4", int'(h), 1, "way 0 kept");
        probe(16'h0350, h, w);
        check("R4", int'(h), 1, "way 2 kept");
        probe(16'h0450, h, w);
        check("R4", int'(h), 1, "way 3 kept");

        // R6: lookups stall the walk; R3 still holds afterwards
        install(16'h0777, 1);
        scrub(16'h0700, 16'h0100, 3, 1'b0, n);
        check("R6", n, SETS + 3, "walk length with stalls");
        probe(16'h0777, h, w);
        check("R3", int'(h), 0, "line cleared after stalled walk");

        // R2: request raised during a walk is ignored
        install(16'h0300, 0);
        scrub(16'h2000, 16'h0010, 0, 1'b1, n);
        check("R5", n, SETS, "walk length with ignored request");
        probe(16'h0300, h, w);
        check("R2", int'(h), 1, "ignored request left line valid");
        check("R2", int'(req_ready), 1, "idle after ignored request");

        // R7: zero length, R10 top-of-space range keeps low lines
        install(16'h0001, 3);
        scrub(16'hFFFF, 16'h0004, 0, 1'b0, n);
        probe(16'h0001, h, w);
        check("R10", int'(h), 1, "no wrap past top");
        scrub(16'h0000, 16'h0000, 0, 1'b0, n);
        check("R7", n, SETS, "empty range still walks");
        probe(16'h0001, h, w);
        check("R7", int'(h), 1, "empty range clears nothing");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule